// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a synthesizable model of a small synchronous static RAM. Reads and writes can follow each other on every clock with no idle cycle between them. Address, chip enables, the read/write select and the per-byte write enables are captured on the rising clock edge. The data for a write arrives on the write-data bus a fixed number of edges after its address. While that data is still in flight, a read of the same location must see it, so the block forwards pending write data to reads.

A static `flow_thru` input picks the read timing. In pipelined mode (`flow_thru` = 0), read data passes through an output register. The first beat of a burst therefore appears one edge later than in flow-through mode (`flow_thru` = 1), where read data leaves the array directly. The late-write distance follows the mode: two edges when pipelined and one edge in flow-through. A static `il_order` input picks linear or interleaved stepping of the two low address bits during a burst. An `adv` input continues the current burst instead of loading a new address. Output enable acts asynchronously on the data drive.

The word is made of `BYTES` bytes of `BYTE_W` bits, 2 × 9 bits by default. The depth is 2^`ADDR_W` words, 64 by default.

Top module: `nbt_sram`

## Requirements
- R1: On the first cycle after a synchronous active-low reset, `dq_drv` is 0. Every location then reads as zero until it is written.
- R2: With `flow_thru` = 0, a read loaded at edge n puts its word on `dq_out` with `dq_drv` = 1 from edge n+1 until edge n+2.
- R3: With `flow_thru` = 1, a read loaded at edge n puts its word on `dq_out` with `dq_drv` = 1 from edge n until edge n+1.
- R4: The data of a write whose address is taken at edge n is taken from `wdata` at edge n+2 when `flow_thru` = 0 and at edge n+1 when `flow_thru` = 1. Values on `wdata` at other edges are never stored, and a write never turns on `dq_drv`.
- R5: `bwe_n` is sampled with the address, one bit per byte and active low. `bwe_n[0]` guards bits 8:0 and `bwe_n[1]` guards bits 17:9. A byte whose enable is high keeps its stored value.
- R6: Any mix of reads and writes runs at one operation per edge. A read of a location with a write still pending returns that write's bytes merged over the stored word.
- R7: A load cycle (`adv` = 0) is selected only when `ce_a_n` = 0, `ce_b` = 1 and `ce_c_n` = 0. A load that is not selected stores nothing and drives nothing.
- R8: With `adv` = 1 the block repeats the kind of the last load (read, write or deselect) at the next burst address. `ce_a_n`, `ce_b`, `ce_c_n`, `we_n` and `addr` are ignored, while `bwe_n` still applies to each write beat.
- R9: Beat k (k = 1, 2, 3, then wrapping to 0) keeps the upper address bits of the loaded address s. It takes low bits (s + k) mod 4 when `il_order` = 0, and s XOR k when `il_order` = 1.
- R10: `oe_n` = 1 forces `dq_drv` to 0 at once, without waiting for a clock edge. `dq_out` is all zeros whenever `dq_drv` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flow_thru | input | 1 | Static read mode: 1 flow-through, 0 pipelined |
| il_order | input | 1 | Static burst order: 1 interleaved, 0 linear |
| ce_a_n | input | 1 | Chip enable A, active low |
| ce_b | input | 1 | Chip enable B, active high |
| ce_c_n | input | 1 | Chip enable C, active low |
| adv | input | 1 | 1 continues the burst, 0 loads a new address |
| we_n | input | 1 | On a load: 0 write, 1 read |
| addr | input | ADDR_W | Word address, taken on a load |
| bwe_n | input | BYTES | Active-low byte write enables |
| wdata | input | BYTES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | BYTES*BYTE_W | Read data, zero when not driven |
| dq_drv | output | 1 | High while read data is driven |

## Verification
The checker watches, on every edge, the link between a selected read load and the drive that follows it in each mode. It also checks that deselects and flow-through writes leave the bus quiet and that `oe_n` releases the bus. Only the bench scenarios can show which data comes out. That covers late-write timing, the merging of pending bytes, the burst address order for both settings and every chip enable held off in turn. They are compared cycle by cycle against a behavioural model that keeps queues of pending writes and reads.

// File: rtl/nbt_sram_pkg.sv
// Shared definitions for the zero-turnaround SRAM.
// Assumes bursts span the two low address bits and that at most two
// edges separate a write address from its data.
package nbt_sram_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

    localparam int BURST_W  = 2;   // low address bits walked by a burst
    localparam int LATE_MAX = 2;   // deepest late-write distance (pipelined)

    // Low address bits of burst beat k from start s (R9).
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] s,
        input logic [BURST_W-1:0] k,
        input logic               interleave
    );
        return interleave ? (s ^ k) : (s + k);
    endfunction

endpackage

// File: rtl/nbt_burst_gen.sv
// Burst and operation decoder.
// On a load it turns the chip enables and we_n into an operation at the given
// address. On an advance it repeats the last loaded kind at the next burst
// address (R8, R9). Assumes ADDR_W is larger than the burst width.
module nbt_burst_gen
    import nbt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              adv,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTES-1:0]  bwe_n,
    input  logic              il_order,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [BYTES-1:0]  op_be
);

    localparam int HI_W = ADDR_W - BURST_W;

    op_kind_e             kind_q;
    logic [ADDR_W-1:0]    base_q;
    logic [BURST_W-1:0]   cnt_q;
    logic [BURST_W-1:0]   cnt_nx;

    assign cnt_nx = cnt_q + 1'b1;

    // Decode this edge's operation from the pins or from the burst state.
    always_comb begin
        if (adv) begin
            op_kind = kind_q;
            op_addr = {base_q[ADDR_W-1 -: HI_W],
                       burst_low(base_q[BURST_W-1:0], cnt_nx, il_order)};
        end else begin
            op_addr = addr;
            if (!sel)      op_kind = OP_NONE;
            else if (we_n) op_kind = OP_READ;
            else           op_kind = OP_WRITE;
        end
        op_be = (op_kind == OP_WRITE) ? ~bwe_n : '0;
    end

    // Hold the loaded kind and base address; step the beat count on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OP_NONE;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (adv) begin
            cnt_q  <= cnt_nx;
        end else begin
            kind_q <= op_kind;
            base_q <= addr;
            cnt_q  <= '0;
        end
    end

endmodule

// File: rtl/nbt_late_pipe.sv
// Late-write delay line.
// It carries each operation through LATE_MAX stages. Stage 0 is the access
// cycle and supplies the read address. The commit stage is stage 0 in
// flow-through mode and stage 1 in pipelined mode, so write data is taken
// one or two edges after the address (R4). Assumes flow_thru changes only
// during reset.
module nbt_late_pipe
    import nbt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flow_thru,
    input  op_kind_e          op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [BYTES-1:0]  op_be,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTES-1:0]  wr_be
);

    op_kind_e          kind_q [LATE_MAX];
    logic [ADDR_W-1:0] addr_q [LATE_MAX];
    logic [BYTES-1:0]  be_q   [LATE_MAX];
    logic              cs;

    // Shift operations down the stages every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LATE_MAX; i++) begin
                kind_q[i] <= OP_NONE;
                addr_q[i] <= '0;
                be_q[i]   <= '0;
            end
        end else begin
            kind_q[0] <= op_kind;
            addr_q[0] <= op_addr;
            be_q[0]   <= op_be;
            for (int i = 1; i < LATE_MAX; i++) begin
                kind_q[i] <= kind_q[i-1];
                addr_q[i] <= addr_q[i-1];
                be_q[i]   <= be_q[i-1];
            end
        end
    end

    // Choose the commit stage from the read mode.
    always_comb begin
        cs      = flow_thru ? 1'b0 : 1'b1;
        rd_req  = (kind_q[0] == OP_READ);
        rd_addr = addr_q[0];
        wr_en   = (kind_q[cs] == OP_WRITE);
        wr_addr = addr_q[cs];
        wr_be   = be_q[cs];
    end

endmodule

// File: rtl/nbt_array.sv
// Storage array with forwarding and output stage.
// Asynchronous read of the stage-0 address. Bytes that commit on the
// same edge are forwarded over the stored word (R6). An optional output
// register serves pipelined mode (R2); flow-through drives straight
// from the array (R3). oe_n gates the drive without a clock (R10).
module nbt_array #(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9,
    parameter int BYTES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flow_thru,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [BYTES-1:0]        wr_be,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic                    rd_req,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    oe_n,
    output logic [BYTES*BYTE_W-1:0] dq_out,
    output logic                    dq_drv
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int DW    = BYTES * BYTE_W;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] fwd;
    logic [DW-1:0] out_q;
    logic          out_v;
    logic          hit;

    assign hit = wr_en && (wr_addr == rd_addr);

    // Per-byte merge of committing data over the stored word.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign fwd[b*BYTE_W +: BYTE_W] = (hit && wr_be[b]) ? wdata[b*BYTE_W +: BYTE_W]
                                                           : mem[rd_addr][b*BYTE_W +: BYTE_W];
    end

    // Clear the array on reset; commit enabled bytes otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wr_be[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
    end

    // Output register for pipelined reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            out_v <= 1'b0;
        end else begin
            out_v <= rd_req;
            if (rd_req) out_q <= fwd;
        end
    end

    // Drive select and asynchronous output enable.
    always_comb begin
        dq_drv = !oe_n && (flow_thru ? rd_req : out_v);
        dq_out = dq_drv ? (flow_thru ? fwd : out_q) : '0;
    end

endmodule

// File: rtl/nbt_sram.sv
// Top of the zero-turnaround late-write SRAM.
// Combines the three chip enables (R7) and wires the burst decoder, the
// late-write pipe and the array together. flow_thru and il_order are
// expected static outside reset.
module nbt_sram
    import nbt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 9,
    parameter int BYTES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flow_thru,
    input  logic                    il_order,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic                    adv,
    input  logic                    we_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES-1:0]        bwe_n,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [BYTES*BYTE_W-1:0] dq_out,
    output logic                    dq_drv
);

    logic              sel;
    op_kind_e          op_kind;
    logic [ADDR_W-1:0] op_addr;
    logic [BYTES-1:0]  op_be;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTES-1:0]  wr_be;

    assign sel = !ce_a_n && ce_b && !ce_c_n;

    nbt_burst_gen #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_burst (
        .clk(clk), .rst_n(rst_n), .sel(sel), .adv(adv), .we_n(we_n),
        .addr(addr), .bwe_n(bwe_n), .il_order(il_order),
        .op_kind(op_kind), .op_addr(op_addr), .op_be(op_be)
    );

    nbt_late_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru),
        .op_kind(op_kind), .op_addr(op_addr), .op_be(op_be),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be)
    );

    nbt_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BYTES(BYTES)) u_array (
        .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wdata(wdata),
        .rd_req(rd_req), .rd_addr(rd_addr), .oe_n(oe_n),
        .dq_out(dq_out), .dq_drv(dq_drv)
    );

endmodule

// File: rtl/nbt_sram_chk.sv
// Port-level protocol checker for nbt_sram, bound to every instance.
// Relates load cycles to the drive seen one or two edges later.
module nbt_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic flow_thru,
    input logic ce_a_n,
    input logic ce_b,
    input logic ce_c_n,
    input logic adv,
    input logic we_n,
    input logic oe_n,
    input logic dq_drv
);

    logic sel;
    assign sel = !ce_a_n && ce_b && !ce_c_n;

    // R10: output enable high means no drive
    p_oe_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_drv);

    // R1: first cycle out of reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !dq_drv);

    // R3: flow-through read drives right after its load edge
    p_flow_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_thru && !adv && sel && we_n) |=> (oe_n || dq_drv));

    // R2: pipelined read drives one edge later
    p_pipe_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_thru && !adv && sel && we_n) |=> ##1 (oe_n || dq_drv));

    // R4: flow-through write leaves the bus quiet in its access cycle
    p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_thru && !adv && sel && !we_n) |=> !dq_drv);

    // R7: deselected load never drives (flow-through timing)
    p_desel_flow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_thru && !adv && !sel) |=> !dq_drv);

    // R7: deselected load never drives (pipelined timing)
    p_desel_pipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_thru && !adv && !sel) |=> ##1 !dq_drv);

endmodule

bind nbt_sram nbt_sram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .adv(adv), .we_n(we_n), .oe_n(oe_n), .dq_drv(dq_drv)
);

// File: tb/sim_nbt_sram.sv
// Bench for nbt_sram: a queue-based behavioural model predicts the bus on every cycle.
module sim_nbt_sram;

    localparam int AW = 6;
    localparam int BW = 9;
    localparam int NB = 2;
    localparam int DW = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk;
    logic          rst_n;
    logic          flow_thru;
    logic          il_order;
    logic          ce_a_n, ce_b, ce_c_n;
    logic          adv, we_n, oe_n;
    logic [AW-1:0] addr;
    logic [NB-1:0] bwe_n;
    logic [DW-1:0] wdata;
    logic [DW-1:0] dq_out;
    logic          dq_drv;

    nbt_sram #(.ADDR_W(AW), .BYTE_W(BW), .BYTES(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .il_order(il_order),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .adv(adv), .we_n(we_n),
        .addr(addr), .bwe_n(bwe_n), .wdata(wdata), .oe_n(oe_n),
        .dq_out(dq_out), .dq_drv(dq_drv)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    task automatic check(input bit ok, input string req, input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural model ----------------
    logic [DW-1:0] m_mem [DEPTH];
    int  cyc = 0;
    int  m_kind = 0, m_base = 0, m_cnt = 0;
    int  wq_addr[$], wq_be[$], wq_due[$];
    int  rq_addr[$], rq_due[$];
    bit  exp_rd = 0;
    logic [DW-1:0] exp_val = '0;
    logic [DW-1:0] din_sched [int];

    always @(posedge clk) begin
        int k, a, be, lo, wa, wb;
        bit s;
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
            wq_addr.delete(); wq_be.delete(); wq_due.delete();
            rq_addr.delete(); rq_due.delete();
            m_kind = 0; m_base = 0; m_cnt = 0; exp_rd = 0;
        end else begin
            while (wq_due.size() > 0 && wq_due[0] == cyc) begin
                wa = wq_addr.pop_front();
                wb = wq_be.pop_front();
                void'(wq_due.pop_front());
                for (int b = 0; b < NB; b++)
                    if (wb[b]) m_mem[wa][b*BW +: BW] = wdata[b*BW +: BW];
            end
            if (adv) begin
                m_cnt = (m_cnt + 1) % 4;
                k  = m_kind;
                lo = il_order ? ((m_base % 4) ^ m_cnt) : (((m_base % 4) + m_cnt) % 4);
                a  = (m_base / 4) * 4 + lo;
            end else begin
                s = !ce_a_n && ce_b && !ce_c_n;
                k = !s ? 0 : (we_n ? 1 : 2);
                a = int'(addr);
                m_kind = k; m_base = a; m_cnt = 0;
            end
            be = int'(~bwe_n);
            if (k == 2) begin
                wq_addr.push_back(a); wq_be.push_back(be);
                wq_due.push_back(cyc + (flow_thru ? 1 : 2));
            end
            if (k == 1) begin
                rq_addr.push_back(a);
                rq_due.push_back(cyc + (flow_thru ? 0 : 1));
            end
            exp_rd = 0;
            if (rq_due.size() > 0 && rq_due[0] == cyc) begin
                exp_rd  = 1;
                exp_val = m_mem[rq_addr.pop_front()];
                void'(rq_due.pop_front());
            end
        end
    end

    // Compare the bus against the model away from the active edge.
    always @(negedge clk) begin
        logic [DW:0] e;
        e = (exp_rd && !oe_n) ? {1'b1, exp_val} : '0;
        check({dq_drv, dq_out} === e, cur_req, {dq_drv, dq_out}, e);
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input bit a_adv, input int off, input bit wr, input int a,
                         input logic [NB-1:0] bw, input logic [DW-1:0] d);
        int e;
        @(negedge clk); #2;
        e = cyc + 1;
        adv    = a_adv;
        ce_a_n = (off == 1);
        ce_b   = a_adv ? 1'b0 : !(off == 2);   // R8: ignored on advance
        ce_c_n = (off == 3);
        we_n   = a_adv ? wr : !wr;             // R8: inverted junk on advance
        addr   = a_adv ? AW'(~a) : AW'(a);
        bwe_n  = bw;
        if (wr) din_sched[e + (flow_thru ? 1 : 2)] = d;
        wdata  = din_sched.exists(e) ? din_sched[e] : (18'h2AAAA ^ 18'(e));
    endtask

    task automatic ld_rd(input int a);                        drive(0, 0, 0, a, 2'b11, '0); endtask
    task automatic ld_wr(input int a, input logic [DW-1:0] d, input logic [NB-1:0] bw); drive(0, 0, 1, a, bw, d); endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 2, 0, 0, 2'b11, '0);
    endtask
    task automatic nx_rd();                                    drive(1, 0, 0, 0, 2'b11, '0); endtask
    task automatic nx_wr(input logic [DW-1:0] d, input logic [NB-1:0] bw); drive(1, 0, 1, 0, bw, d); endtask

    task automatic do_reset(input bit f, input bit il);
        @(negedge clk); #2;
        rst_n = 0; flow_thru = f; il_order = il; adv = 0; ce_b = 0;
        repeat (3) @(negedge clk);
        #2 rst_n = 1;
        @(negedge clk); #1;
        check(dq_drv === 1'b0, "R1", {dq_drv, dq_out}, '0);
    endtask

    task automatic oe_probe(input string req);
        // Called right after the edge at which read data becomes visible.
        #3;
        check(dq_drv === 1'b1, req, {dq_drv, dq_out}, {1'b1, dq_out});
        oe_n = 1'b1; #1;
        check(dq_drv === 1'b0 && dq_out === '0, "R10", {dq_drv, dq_out}, '0);
        oe_n = 1'b0; #1;
        check(dq_drv === 1'b1, "R10", {dq_drv, dq_out}, {1'b1, dq_out});
    endtask

    // ---------------- scenarios ----------------
    initial begin
        rst_n = 0; flow_thru = 0; il_order = 0; ce_a_n = 1; ce_b = 0; ce_c_n = 1;
        adv = 0; we_n = 1; oe_n = 0; addr = '0; bwe_n = '1; wdata = '0;

        // Pipelined, linear order
        do_reset(0, 0);
        cur_req = "R1"; ld_rd(5); ld_rd(63); idle(3);
        cur_req = "R4"; ld_wr(3, 18'h12345, 2'b00); idle(3); ld_rd(3); idle(3);
        cur_req = "R2"; ld_rd(3); ld_rd(5); ld_rd(3); idle(3);
        cur_req = "R6";
        ld_wr(7, 18'h0AAAA, 2'b00); ld_rd(7); ld_wr(8, 18'h15555, 2'b00); ld_rd(8);
        ld_rd(7); ld_wr(7, 18'h3C3C3, 2'b00); ld_rd(7); idle(4);
        cur_req = "R5";
        ld_wr(9, 18'h3FFFF, 2'b00); ld_wr(9, 18'h00000, 2'b10); ld_rd(9);
        ld_wr(9, 18'h2A955, 2'b01); ld_rd(9); idle(4);
        cur_req = "R7";
        ld_wr(10, 18'h0F0F0, 2'b00); idle(3);
        for (int w = 1; w <= 3; w++) drive(0, w, 1, 10, 2'b00, 18'h31111);
        for (int w = 1; w <= 3; w++) drive(0, w, 0, 10, 2'b11, '0);
        idle(3); ld_rd(10); idle(3);
        cur_req = "R8";
        ld_wr(13, 18'h00101, 2'b00); nx_wr(18'h00202, 2'b00); nx_wr(18'h00303, 2'b10);
        nx_wr(18'h00404, 2'b00); nx_wr(18'h00505, 2'b00); idle(3);
        cur_req = "R9";
        ld_rd(13); nx_rd(); nx_rd(); nx_rd(); nx_rd(); ld_rd(14); idle(3);
        cur_req = "R8"; drive(0, 2, 0, 0, 2'b11, '0); nx_rd(); nx_rd(); idle(3);
        cur_req = "R2"; ld_rd(14); idle(1); @(posedge clk); oe_probe("R2"); idle(3);

        // Flow-through, interleaved order
        do_reset(1, 1);
        cur_req = "R3"; ld_wr(20, 18'h1ABCD, 2'b00); ld_rd(20); ld_rd(21); idle(3);
        cur_req = "R4"; ld_wr(24, 18'h22222, 2'b01); ld_rd(24); idle(3);
        cur_req = "R6";
        ld_rd(30); ld_wr(30, 18'h13579, 2'b00); ld_rd(30); ld_wr(31, 18'h2468A, 2'b00);
        ld_rd(31); ld_wr(30, 18'h00011, 2'b10); ld_rd(30); idle(3);
        cur_req = "R9";
        ld_wr(22, 18'h0C001, 2'b00); nx_wr(18'h0C002, 2'b00); nx_wr(18'h0C003, 2'b00);
        nx_wr(18'h0C004, 2'b00); idle(2);
        ld_rd(23); nx_rd(); nx_rd(); nx_rd(); nx_rd(); idle(3);
        cur_req = "R3"; ld_rd(20); @(posedge clk); oe_probe("R3"); idle(3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule